// File: doc/BRIEF.md
# Pre-Bias Safe Synchronous Rectifier Ramp

This block sits between a digital PWM modulator and the gate drivers of a synchronous buck stage. It works in fine ticks of its clock. A strobe marks the start of each switching period. At that strobe it captures the commanded high-side on-time, limits it to the maximum duty cycle, and drops it entirely if it is shorter than the minimum on-time. From that it builds the high-side and low-side gate enables for the period, with a dead gap at both handoffs.

When the output is already charged at startup, a full-width low-side pulse would pull current out of the load. The block therefore stays silent while the soft-start reference is below the feedback voltage. Once the reference passes feedback, it starts the low-side switch with a narrow on-time and widens it by a fixed step every period. The low-side width stops growing when it fills the whole gap between the high-side pulse and the period end, minus the two dead gaps. From then on the stage runs fully complementary until the next restart.

The controller has three states. `ST_WAIT` emits nothing. `ST_RAMP` applies the growing low-side width. `ST_FULL` applies the saturated width and raises the done flag. The transitions are:
- *arm*: `ST_WAIT` to `ST_RAMP`, at a strobe with the reference above feedback and no inhibit.
- *saturate*: `ST_RAMP` to `ST_FULL`, at a strobe where the grown width reaches the complementary width.
- *restart*: any state to `ST_WAIT`, on any cycle where the inhibit is high or the reference is low.

Top module: `prb_sr_ramp`

## Requirements
- R1: During and right after reset, `hs_gate`, `ls_gate` and `ramp_done` are all 0.
- R2: While `ref_over_fb` is 0, `hs_gate` and `ls_gate` stay 0 in every tick.
- R3: In the first period armed by a strobe, the low-side width is LS_INIT ticks, capped at the complementary width. The low-side pulse begins DEAD ticks after the high-side pulse ends, and the high-side pulse occupies ticks 0 to hs-1 of the period.
- R4: In each later period of `ST_RAMP`, the low-side width is the previous width plus LS_STEP, capped at PERIOD minus the high-side width minus 2*DEAD.
- R5: `ramp_done` goes to 1 in the first period whose low-side width reaches that cap. It then stays at 1, and every later period uses the full cap, until a restart.
- R6: `hs_gate` and `ls_gate` are never high in the same tick. At least DEAD low ticks separate the fall of `hs_gate` from the rise of `ls_gate`, and the fall of `ls_gate` from the end of the period.
- R7: A command above PERIOD*DMAX_PCT/100 ticks (90 by default) is clamped to that value.
- R8: A command below MIN_ON ticks gives no high-side pulse at all, and the low-side pulse then starts at tick DEAD.
- R9: `fault_inhibit` forces both gates to 0 in the same cycle. From the next edge it returns the state to `ST_WAIT` and clears `ramp_done`, so the ramp restarts from LS_INIT.
- R10: `ref_over_fb` falling returns the state to `ST_WAIT` and clears `ramp_done` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fine tick clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_strobe | input | 1 | Period start, one tick wide |
| hs_cmd | input | CW | Commanded high-side on-time in ticks |
| ref_over_fb | input | 1 | Soft-start reference is above feedback |
| fault_inhibit | input | 1 | Thermal or fault shutdown request |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |
| ramp_done | output | 1 | Low-side width has reached full complement |

## Verification
A strobe captured at clock edge k sets the position counter to 0 and latches both widths at that same edge. The gate pattern of tick t of that period is therefore visible after edge k+t. `ramp_done` reflects the state register from the edge after its decision. The inhibit and the reference flag gate the outputs combinationally, so they act within the cycle they are applied. The bench drives inputs just after a falling edge, lets the next rising edge capture them, and queues the expected pattern for that tick. A monitor then pops and compares it at the following falling edge, so each result is compared exactly one half-cycle after the edge that produces it.

// File: rtl/prb_pkg.sv
package prb_pkg;
    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_RAMP = 2'd1,
        ST_FULL = 2'd2
    } prb_state_e;
endpackage

// File: rtl/prb_duty_limit.sv
module prb_duty_limit #(
    parameter int PERIOD   = 100,
    parameter int DMAX_PCT = 90,
    parameter int MIN_ON   = 4,
    parameter int DEAD     = 2,
    parameter int CW       = $clog2(PERIOD + 1)
) (
    input  logic [CW-1:0] hs_cmd,
    output logic [CW-1:0] hs_eff,
    output logic [CW-1:0] ls_full
);
    localparam logic [CW-1:0] HS_MAX  = CW'(PERIOD * DMAX_PCT / 100);
    localparam logic [CW-1:0] MIN_C   = CW'(MIN_ON);
    localparam logic [CW-1:0] SPAN    = CW'(PERIOD - 2 * DEAD);

    logic [CW-1:0] hs_lim;

    always_comb begin
        hs_lim  = (hs_cmd > HS_MAX) ? HS_MAX : hs_cmd;
        hs_eff  = (hs_lim < MIN_C) ? '0 : hs_lim;
        ls_full = SPAN - hs_eff;
    end
endmodule

// File: rtl/prb_ramp_fsm.sv
module prb_ramp_fsm
    import prb_pkg::*;
#(
    parameter int PERIOD  = 100,
    parameter int LS_INIT = 4,
    parameter int LS_STEP = 4,
    parameter int CW      = $clog2(PERIOD + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe,
    input  logic          ref_ok,
    input  logic          inhibit,
    input  logic [CW-1:0] ls_full,
    output logic [CW-1:0] ls_width,
    output logic          active,
    output logic          done
);
    localparam logic [CW-1:0] INIT_C = CW'(LS_INIT);
    localparam logic [CW:0]   STEP_C = (CW+1)'(LS_STEP);
    localparam logic [CW:0]   TOP_C  = (CW+1)'(PERIOD);

    prb_state_e    st_q, st_d;
    logic [CW-1:0] cur_q, cur_d;
    logic [CW-1:0] wid_q, wid_d;
    logic [CW:0]   grown;

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_WAIT;
            cur_q <= '0;
            wid_q <= '0;
        end else begin
            st_q  <= st_d;
            cur_q <= cur_d;
            wid_q <= wid_d;
        end
    end

    // next-state process
    always_comb begin
        st_d  = st_q;
        cur_d = cur_q;
        wid_d = wid_q;
        grown = {1'b0, cur_q} + STEP_C;
        if (grown > TOP_C) grown = TOP_C;
        if (inhibit || !ref_ok) begin
            st_d = ST_WAIT;                                  // restart
        end else if (strobe) begin
            unique case (st_q)
                ST_WAIT: begin                               // arm
                    st_d  = ST_RAMP;
                    cur_d = INIT_C;
                    wid_d = (INIT_C < ls_full) ? INIT_C : ls_full;
                end
                ST_RAMP: begin
                    cur_d = grown[CW-1:0];
                    wid_d = (grown < {1'b0, ls_full}) ? grown[CW-1:0] : ls_full;
                    if (grown >= {1'b0, ls_full}) st_d = ST_FULL; // saturate
                end
                ST_FULL: wid_d = ls_full;
                default: st_d = ST_WAIT;
            endcase
        end
    end

    // output process
    always_comb begin
        ls_width = wid_q;
        active   = (st_q != ST_WAIT);
        done     = (st_q == ST_FULL);
    end

    // R5
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ref_ok && !inhibit) |=> done);

    // R10
    ref_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_ok |=> (!done && !active));

    // R9
    inh_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |=> !active);
endmodule

// File: rtl/prb_gate_gen.sv
module prb_gate_gen #(
    parameter int PERIOD   = 100,
    parameter int DMAX_PCT = 90,
    parameter int DEAD     = 2,
    parameter int CW       = $clog2(PERIOD + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe,
    input  logic [CW-1:0] hs_eff,
    input  logic [CW-1:0] ls_width,
    input  logic          active,
    input  logic          ref_ok,
    input  logic          inhibit,
    output logic          hs_gate,
    output logic          ls_gate
);
    localparam logic [CW-1:0] LAST_C = CW'(PERIOD - 1);
    localparam logic [CW:0]   DEAD_C = (CW+1)'(DEAD);
    localparam logic [CW-1:0] HSMX_C = CW'(PERIOD * DMAX_PCT / 100);

    logic [CW-1:0] pos_q;
    logic [CW-1:0] hsw_q;
    logic [CW:0]   lo_start, lo_end;
    logic          allow;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= LAST_C;
            hsw_q <= '0;
        end else if (strobe) begin
            pos_q <= '0;
            hsw_q <= hs_eff;
        end else if (pos_q != LAST_C) begin
            pos_q <= pos_q + 1'b1;
        end
    end

    always_comb begin
        allow    = active && ref_ok && !inhibit;
        lo_start = {1'b0, hsw_q} + DEAD_C;
        lo_end   = lo_start + {1'b0, ls_width};
        hs_gate  = allow && (pos_q < hsw_q);
        ls_gate  = allow && ({1'b0, pos_q} >= lo_start) && ({1'b0, pos_q} < lo_end);
    end

    // R6
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate && ls_gate));

    // R6
    dead_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_gate) |-> !ls_gate);

    // R7
    duty_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_gate |-> (pos_q < HSMX_C));

    // R9
    inhibit_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |-> (!hs_gate && !ls_gate));

    // R2
    ref_low_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_ok |-> (!hs_gate && !ls_gate));
endmodule

// File: rtl/prb_sr_ramp.sv
module prb_sr_ramp #(
    parameter int PERIOD   = 100,
    parameter int DMAX_PCT = 90,
    parameter int MIN_ON   = 4,
    parameter int DEAD     = 2,
    parameter int LS_INIT  = 4,
    parameter int LS_STEP  = 4,
    localparam int CW      = $clog2(PERIOD + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwm_strobe,
    input  logic [CW-1:0] hs_cmd,
    input  logic          ref_over_fb,
    input  logic          fault_inhibit,
    output logic          hs_gate,
    output logic          ls_gate,
    output logic          ramp_done
);
    logic [CW-1:0] hs_eff, ls_full, ls_width;
    logic          active;

    prb_duty_limit #(
        .PERIOD(PERIOD), .DMAX_PCT(DMAX_PCT), .MIN_ON(MIN_ON), .DEAD(DEAD), .CW(CW)
    ) u_limit (
        .hs_cmd (hs_cmd),
        .hs_eff (hs_eff),
        .ls_full(ls_full)
    );

    prb_ramp_fsm #(
        .PERIOD(PERIOD), .LS_INIT(LS_INIT), .LS_STEP(LS_STEP), .CW(CW)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (pwm_strobe),
        .ref_ok  (ref_over_fb),
        .inhibit (fault_inhibit),
        .ls_full (ls_full),
        .ls_width(ls_width),
        .active  (active),
        .done    (ramp_done)
    );

    prb_gate_gen #(
        .PERIOD(PERIOD), .DMAX_PCT(DMAX_PCT), .DEAD(DEAD), .CW(CW)
    ) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (pwm_strobe),
        .hs_eff  (hs_eff),
        .ls_width(ls_width),
        .active  (active),
        .ref_ok  (ref_over_fb),
        .inhibit (fault_inhibit),
        .hs_gate (hs_gate),
        .ls_gate (ls_gate)
    );
endmodule

// File: tb/prb_sr_ramp_tb.sv
module prb_sr_ramp_tb;
    localparam int PERIOD = 100;
    localparam int DEAD   = 2;
    localparam int MIN_ON = 4;
    localparam int INIT   = 4;
    localparam int STEP   = 4;
    localparam int HS_MAX = 90;
    localparam int CW     = $clog2(PERIOD + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwm_strobe = 1'b0;
    logic [CW-1:0] hs_cmd = '0;
    logic          ref_over_fb = 1'b0;
    logic          fault_inhibit = 1'b0;
    logic          hs_gate, ls_gate, ramp_done;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic  hs;
        logic  ls;
        logic  done;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    // model of the requirements: 0 wait, 1 ramp, 2 full
    int m_st = 0, m_pos = PERIOD - 1, m_hs = 0, m_w = 0, m_cur = 0;

    always #10 clk = ~clk;

    prb_sr_ramp u_dut (
        .clk(clk), .rst_n(rst_n), .pwm_strobe(pwm_strobe), .hs_cmd(hs_cmd),
        .ref_over_fb(ref_over_fb), .fault_inhibit(fault_inhibit),
        .hs_gate(hs_gate), .ls_gate(ls_gate), .ramp_done(ramp_done)
    );

    task automatic model_edge(input logic stb, input int hs, input logic rf, input logic inh);
        int lim, full;
        lim  = (hs > HS_MAX) ? HS_MAX : hs;           // R7
        if (lim < MIN_ON) lim = 0;                     // R8
        full = PERIOD - lim - 2 * DEAD;                // R4 cap
        if (inh || !rf) begin
            m_st = 0;                                  // R9 / R10
        end else if (stb) begin
            if (m_st == 0) begin
                m_st = 1; m_cur = INIT;
                m_w = (INIT < full) ? INIT : full;     // R3
            end else if (m_st == 1) begin
                m_cur = m_cur + STEP;
                if (m_cur > PERIOD) m_cur = PERIOD;
                m_w = (m_cur < full) ? m_cur : full;   // R4
                if (m_cur >= full) m_st = 2;           // R5
            end else begin
                m_w = full;
            end
        end
        if (stb) begin
            m_pos = 0;
            m_hs = lim;
        end else if (m_pos < PERIOD - 1) begin
            m_pos++;
        end
    endtask

    task automatic tick(input logic stb, input int hs, input logic rf, input logic inh,
                        input string tag);
        exp_t e;
        logic en;
        pwm_strobe    = stb;
        hs_cmd        = CW'(hs);
        ref_over_fb   = rf;
        fault_inhibit = inh;
        @(posedge clk);
        model_edge(stb, hs, rf, inh);
        en     = (m_st != 0) && rf && !inh;
        e.hs   = en && (m_pos < m_hs);
        e.ls   = en && (m_pos >= m_hs + DEAD) && (m_pos < m_hs + DEAD + m_w);
        e.done = (m_st == 2);
        e.tag  = tag;
        #1;
        sb_q.push_back(e);
        @(negedge clk);
        #1;
    endtask

    task automatic run_period(input int hs, input logic rf, input int inh_lo, input int inh_hi,
                              input int rf_drop, input string tag);
        for (int t = 0; t < PERIOD; t++) begin
            tick(t == 0, hs, (rf_drop >= 0 && t >= rf_drop) ? 1'b0 : rf,
                 (t >= inh_lo && t < inh_hi), tag);
        end
    endtask

    // monitor: pop and compare away from the active edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if ({hs_gate, ls_gate, ramp_done} !== {e.hs, e.ls, e.done}) begin
                errors++;
                $display("FAIL %s: hs/ls/done actual %b%b%b expected %b%b%b at %0t",
                         e.tag, hs_gate, ls_gate, ramp_done, e.hs, e.ls, e.done, $time);
            end
            checks++;
            if (hs_gate && ls_gate) begin
                errors++;
                $display("FAIL R6: overlap actual hs=%b ls=%b expected not both high", hs_gate, ls_gate);
            end
        end
    end

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if ({hs_gate, ls_gate, ramp_done} !== 3'b000) begin
            errors++;
            $display("FAIL R1: actual %b%b%b expected 000", hs_gate, ls_gate, ramp_done);
        end
        #1 rst_n = 1'b1;

        // R1: after reset release, still quiet with no strobe
        for (int t = 0; t < 5; t++) tick(1'b0, 40, 1'b0, 1'b0, "R1");
        // R2: reference below feedback, strobes present
        run_period(40, 1'b0, 0, 0, -1, "R2");
        run_period(60, 1'b0, 0, 0, -1, "R2");
        // R3: first armed period
        run_period(40, 1'b1, 0, 0, -1, "R3");
        // R4: ramp growth, cap 56 reached after 13 more periods
        for (int p = 0; p < 12; p++) run_period(40, 1'b1, 0, 0, -1, "R4");
        // R5: saturate and stay full
        for (int p = 0; p < 3; p++) run_period(40, 1'b1, 0, 0, -1, "R5");
        // R7: clamp to 90 ticks
        run_period(95, 1'b1, 0, 0, -1, "R7");
        run_period(100, 1'b1, 0, 0, -1, "R7");
        // R8: short command suppressed
        run_period(3, 1'b1, 0, 0, -1, "R8");
        run_period(2, 1'b1, 0, 0, -1, "R8");
        // R9: inhibit mid-period, then restart from the initial width
        run_period(30, 1'b1, 5, 12, -1, "R9");
        run_period(30, 1'b1, 0, 0, -1, "R9");
        run_period(30, 1'b1, 0, 0, -1, "R9");
        // R10: reference falls mid-period during full operation
        for (int p = 0; p < 16; p++) run_period(30, 1'b1, 0, 0, -1, "R10");
        run_period(30, 1'b1, 0, 0, 50, "R10");
        run_period(30, 1'b1, 0, 0, -1, "R10");
        // R6: wide command exercises both dead gaps
        run_period(88, 1'b1, 0, 0, -1, "R6");

        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule